// File: doc/BRIEF.md
# Infrared Run-Length Transmit Engine

This block drives an infrared emitter from a queue of run-length symbols. A host writes symbol bytes into a 32-deep first-in first-out store. Each byte says whether the line shows light or stays dark, and for how many sample ticks. The engine takes one symbol at a time from the head of the store. It holds that state on the output for the coded number of ticks, then moves to the next symbol. During a light interval the output is not held steadily high: it is chopped by a free-running carrier. The host sets the carrier period in clock cycles, and a 3-bit code sets the share of each period that is high.

The host sees how many slots are occupied and whether the store is full. It can empty the store with a one-cycle clear pulse. It can also pick one of four refill levels. A low-data interrupt then asks for more symbols whenever the occupancy has dropped to that level or below. The sample tick comes from outside, so the length of one tick is chosen elsewhere.

Top module: `irtx_engine`

## Requirements
- R1: The store holds at most 32 bytes. `fifo_full` is high exactly when 32 bytes are held. A write to a full store with no pop in the same cycle is dropped, and the count stays at 32.
- R2: `fill_count` shows the number of occupied slots one cycle after each write, pop or clear. A write and a pop in the same cycle leave the count unchanged.
- R3: A one-cycle pulse on `fifo_clear` makes `fill_count` zero in the next cycle. The clear wins over a write or a pop in the same cycle.
- R4: Symbol byte bit 7 selects the line state. 0 means light, so the output follows the carrier. 1 means dark, so the output stays low.
- R5: Bits 6..0 of a symbol give its duration in sample ticks. A symbol taken at one tick lasts until exactly that many ticks later. A duration of 0 lasts one tick.
- R6: Threshold code 0, 1, 2 and 3 select refill levels of 1, 7, 17 and 25 entries. After reset the code is 2. Writing with `cfg_we` loads `cfg_thresh` and `cfg_pw` together.
- R7: `low_data_irq` is high when three conditions all hold: `ldata_ie` is high, `irq_gate` is high, and `fill_count` is at or below the selected level. With the default combinational variant it follows in the same cycle.
- R8: The carrier repeats every `car_period` clock cycles. In each period it is high for floor(`car_period` × (pw+1) / 8) cycles, where pw is the pulse-width code. After reset pw is 4.
- R9: When the store runs dry and the last symbol has expired, the output stays low. A byte written while the engine is idle is taken at the next sample tick.
- R10: Symbols are played in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle pulse marking one duration unit |
| wr_en | input | 1 | Push `wr_data` into the store |
| wr_data | input | 8 | Symbol byte: bit 7 dark, bits 6..0 duration |
| fifo_clear | input | 1 | Empty the store |
| cfg_we | input | 1 | Load the threshold and pulse-width codes |
| cfg_thresh | input | 2 | Refill level code |
| cfg_pw | input | 3 | Carrier pulse-width code |
| car_period | input | 8 | Carrier period in clock cycles |
| ldata_ie | input | 1 | Low-data interrupt enable |
| irq_gate | input | 1 | Global interrupt enable |
| ir_out | output | 1 | Modulated emitter drive |
| fill_count | output | 6 | Occupied slots |
| fifo_full | output | 1 | Store is full |
| low_data_irq | output | 1 | Refill request |

## Verification
Two actions on the store can land in the same cycle. A host write can meet a pop made by the run timer at a sample tick, and a clear can meet a write. The bench builds each collision on purpose. It raises `wr_en` in the same cycle as `sample_tick` while the engine is waiting for its next symbol, and it raises `fifo_clear` together with `wr_en`. It then checks that the count stays the same for the write and pop, and drops to zero for the clear and write. Playback is judged by counting the high cycles of `ir_out` in each tick window and comparing that number with the one expected from the byte sequence and the carrier settings.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

   localparam int SYM_W = 8;
   localparam int LEN_W = 7;

   typedef struct packed {
      logic             dark;
      logic [LEN_W-1:0] len;
   } irtx_sym_t;

   // refill level selected by a 2-bit code
   function automatic int unsigned refill_level(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 7;
         2'd2:    return 17;
         default: return 25;
      endcase
   endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    wdata,
   input  logic             pop,
   input  logic             clear,
   output logic [DW-1:0]    head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

   logic [DW-1:0]    store [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_MAX);
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty && !clear;
   assign do_push = push && (!full || do_pop) && !clear;
   assign head    = store[rptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_MAX) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) store[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clear) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= bump(wptr);
         if (do_pop)  rptr <= bump(rptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/irtx_runtimer.sv
module irtx_runtimer
   import irtx_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            head_valid,
   input  logic [SYM_W-1:0] head_byte,
   input  logic            block,
   output logic            pop,
   output logic            mark_on
);

   irtx_sym_t        sym;
   logic             active;
   logic             dark;
   logic [LEN_W-1:0] remain;
   logic             need;

   assign sym     = irtx_sym_t'(head_byte);
   assign need    = !active || (remain <= LEN_W'(1));
   assign pop     = tick && need && head_valid && !block;
   assign mark_on = active && !dark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         dark   <= 1'b1;
         remain <= '0;
      end else if (tick) begin
         if (pop) begin
            active <= 1'b1;
            dark   <= sym.dark;
            remain <= (sym.len == '0) ? LEN_W'(1) : sym.len;
         end else if (need) begin
            active <= 1'b0;
            dark   <= 1'b1;
            remain <= '0;
         end else begin
            remain <= remain - 1'b1;
         end
      end
   end

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
   parameter int CAR_W = 8,
   parameter int PW_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAR_W-1:0] period,
   input  logic [PW_W-1:0]  pw,
   output logic             car_high
);

   localparam int PROD_W = CAR_W + PW_W + 1;

   logic [CAR_W-1:0]  cnt;
   logic [CAR_W-1:0]  last;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] hi_len;

   assign last   = (period < CAR_W'(2)) ? CAR_W'(1) : period - 1'b1;
   assign prod   = PROD_W'(period) * (PROD_W'(pw) + PROD_W'(1));
   assign hi_len = prod >> PW_W;
   assign car_high = (PROD_W'(cnt) < hi_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt >= last)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/irtx_irq.sv
module irtx_irq
   import irtx_pkg::*;
#(
   parameter int CNT_W   = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [1:0]       code,
   input  logic             ie,
   input  logic             gate,
   output logic             irq
);

   logic low;
   assign low = ie && gate && (int'(count) <= int'(refill_level(code)));

   generate
      if (IRQ_REG) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= low;
         end
         assign irq = q;
      end else begin : g_comb
         assign irq = low;
      end
   endgenerate

endmodule

// File: rtl/irtx_engine.sv
module irtx_engine
   import irtx_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter int CAR_W   = 8,
   parameter bit IRQ_REG = 1'b0,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_tick,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             fifo_clear,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_thresh,
   input  logic [2:0]       cfg_pw,
   input  logic [CAR_W-1:0] car_period,
   input  logic             ldata_ie,
   input  logic             irq_gate,
   output logic             ir_out,
   output logic [CNT_W-1:0] fill_count,
   output logic             fifo_full,
   output logic             low_data_irq
);

   localparam logic [1:0] THR_RST = 2'd2;
   localparam logic [2:0] PW_RST  = 3'd4;

   generate
      if (DEPTH < 26) begin : g_bad_depth
         $error("irtx_engine: DEPTH must cover the highest refill level");
      end
      if (CAR_W < 2) begin : g_bad_car
         $error("irtx_engine: CAR_W too small");
      end
   endgenerate

   logic [1:0]       thr_code;
   logic [2:0]       pw_code;
   logic [SYM_W-1:0] head;
   logic             empty;
   logic             pop_req;
   logic             mark_on;
   logic             car_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_code <= THR_RST;
         pw_code  <= PW_RST;
      end else if (cfg_we) begin
         thr_code <= cfg_thresh;
         pw_code  <= cfg_pw;
      end
   end

   irtx_fifo #(.DEPTH(DEPTH), .DW(SYM_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en),
      .wdata (wr_data),
      .pop   (pop_req),
      .clear (fifo_clear),
      .head  (head),
      .count (fill_count),
      .full  (fifo_full),
      .empty (empty)
   );

   irtx_runtimer u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sample_tick),
      .head_valid (!empty),
      .head_byte  (head),
      .block      (fifo_clear),
      .pop        (pop_req),
      .mark_on    (mark_on)
   );

   irtx_carrier #(.CAR_W(CAR_W), .PW_W(3)) u_car (
      .clk      (clk),
      .rst_n    (rst_n),
      .period   (car_period),
      .pw       (pw_code),
      .car_high (car_high)
   );

   irtx_irq #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .count (fill_count),
      .code  (thr_code),
      .ie    (ldata_ie),
      .gate  (irq_gate),
      .irq   (low_data_irq)
   );

   assign ir_out = mark_on && car_high;

endmodule

// File: rtl/irtx_engine_chk.sv
module irtx_engine_chk #(
   parameter int DEPTH = 32,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_tick,
   input logic             wr_en,
   input logic             fifo_clear,
   input logic             pop_req,
   input logic             mark_on,
   input logic             ir_out,
   input logic [CNT_W-1:0] fill_count,
   input logic             fifo_full,
   input logic             low_data_irq
);

   localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);
   localparam logic [CNT_W:0] TOP = (CNT_W+1)'(DEPTH);

   // R1: occupancy never exceeds the depth
   a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, fill_count} <= TOP);

   // R1: write to a full store without pop is dropped
   a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && wr_en && !pop_req && !fifo_clear) |=> fifo_full);

   // R3: clear empties in the next cycle
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clear |=> (fill_count == '0));

   // R2: occupancy moves by at most one without a clear
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_clear |=> (({1'b0, fill_count} <= {1'b0, $past(fill_count)} + ONE) &&
                       ({1'b0, fill_count} + ONE >= {1'b0, $past(fill_count)})));

   // R4: light only during a light symbol
   a_r4_dark_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ir_out |-> mark_on);

   // R5: symbols are taken only on sample ticks
   a_r5_pop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req |-> sample_tick);

   // R7: a full store never requests refill
   a_r7_no_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !low_data_irq);

endmodule

bind irtx_engine irtx_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_tick  (sample_tick),
   .wr_en        (wr_en),
   .fifo_clear   (fifo_clear),
   .pop_req      (pop_req),
   .mark_on      (mark_on),
   .ir_out       (ir_out),
   .fill_count   (fill_count),
   .fifo_full    (fifo_full),
   .low_data_irq (low_data_irq)
);

// File: tb/irtx_engine_test.sv
module irtx_engine_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       fifo_clear = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_thresh = 2'd2;
   logic [2:0] cfg_pw = 3'd4;
   logic [7:0] car_period = 8'd16;
   logic       ldata_ie = 1'b1;
   logic       irq_gate = 1'b1;
   logic       ir_out;
   logic [5:0] fill_count;
   logic       fifo_full;
   logic       low_data_irq;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irtx_engine uut (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .wr_en(wr_en), .wr_data(wr_data), .fifo_clear(fifo_clear),
      .cfg_we(cfg_we), .cfg_thresh(cfg_thresh), .cfg_pw(cfg_pw),
      .car_period(car_period), .ldata_ie(ldata_ie), .irq_gate(irq_gate),
      .ir_out(ir_out), .fill_count(fill_count), .fifo_full(fifo_full),
      .low_data_irq(low_data_irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int level_for(input int code);
      case (code)
         0: return 1;
         1: return 7;
         2: return 17;
         default: return 25;
      endcase
   endfunction

   task automatic push(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); fifo_clear = 1'b1;
      @(negedge clk); fifo_clear = 1'b0;
   endtask

   task automatic set_cfg(input int thr, input int pw);
      @(negedge clk); cfg_we = 1'b1; cfg_thresh = 2'(thr); cfg_pw = 3'(pw);
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // one tick followed by a window of gap cycles; returns high cycles seen
   task automatic interval(input int gap, output int highs);
      highs = 0;
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
      if (ir_out) highs++;
      for (int i = 1; i < gap; i++) begin
         @(negedge clk);
         if (ir_out) highs++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int h;
      logic [7:0] seq [5];
      int expv [10];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check(fill_count == 0, "R2 reset count", fill_count, 0);
      check(!fifo_full, "R1 reset full", fifo_full, 0);
      check(!ir_out, "R9 reset idle output", ir_out, 0);

      // default pulse width 4, period 16: 10 high per period, 2 periods per window
      push(8'h01);
      interval(32, h);
      check(h == 20, "R8 default pw highs", h, 20);
      interval(32, h);
      check(h == 0, "R9 idle after drain", h, 0);

      // threshold sweep: default code first, then each code
      for (int c = -1; c < 4; c++) begin
         int code;
         code = (c < 0) ? 2 : c;
         if (c >= 0) set_cfg(c, 4);
         do_clear();
         for (int k = 0; k <= 32; k++) begin
            check(fill_count == 6'(k), "R2 count tracks writes", fill_count, k);
            check(low_data_irq == (k <= level_for(code)), "R6 R7 refill level",
                  low_data_irq, (k <= level_for(code)) ? 1 : 0);
            check(fifo_full == (k == 32), "R1 full flag", fifo_full, (k == 32) ? 1 : 0);
            push(8'(k));
         end
         check(fill_count == 32, "R1 write when full dropped", fill_count, 32);
      end

      // enable combinations at empty
      do_clear();
      for (int e = 0; e < 4; e++) begin
         @(negedge clk); ldata_ie = e[0]; irq_gate = e[1];
         @(negedge clk);
         check(low_data_irq == (e == 3), "R7 enables", low_data_irq, (e == 3) ? 1 : 0);
      end
      ldata_ie = 1'b1; irq_gate = 1'b1;

      // clear colliding with a write
      for (int k = 0; k < 5; k++) push(8'h05);
      @(negedge clk); wr_en = 1'b1; fifo_clear = 1'b1; wr_data = 8'h07;
      @(negedge clk); wr_en = 1'b0; fifo_clear = 1'b0;
      check(fill_count == 0, "R3 clear beats write", fill_count, 0);
      push(8'h07);
      check(fill_count == 1, "R3 write after clear", fill_count, 1);
      do_clear();

      // playback order and durations; pw 4 period 16
      set_cfg(2, 4);
      seq[0] = 8'h03; seq[1] = 8'h82; seq[2] = 8'h00; seq[3] = 8'h80; seq[4] = 8'h01;
      expv = '{20, 20, 20, 0, 0, 20, 0, 20, 0, 0};
      for (int k = 0; k < 5; k++) push(seq[k]);
      for (int i = 0; i < 10; i++) begin
         interval(32, h);
         check(h == expv[i], "R4 R5 R10 playback window", h, expv[i]);
         if (i == 0) check(fill_count == 4, "R2 pop on first tick", fill_count, 4);
      end
      check(fill_count == 0, "R9 drained", fill_count, 0);

      // resume from idle
      push(8'h02);
      interval(32, h);
      check(h == 20, "R9 resume first tick", h, 20);
      interval(32, h);
      check(h == 20, "R5 second tick of run", h, 20);
      interval(32, h);
      check(h == 0, "R9 idle again", h, 0);

      // pulse width sweep
      for (int p = 0; p < 8; p++) begin
         int e;
         set_cfg(2, p);
         e = 2 * ((16 * (p + 1)) / 8);
         push(8'h01);
         interval(32, h);
         check(h == e, "R8 pulse width code", h, e);
         interval(32, h);
         check(h == 0, "R4 dark after mark", h, 0);
      end

      // other carrier period: 10 cycles, pw 4 -> 6 high, 3 periods per window
      set_cfg(2, 4);
      car_period = 8'd10;
      repeat (12) @(negedge clk);
      push(8'h01);
      interval(30, h);
      check(h == 18, "R8 period 10", h, 18);
      interval(30, h);
      car_period = 8'd16;

      // write colliding with a pop at a tick
      push(8'h01);
      push(8'h01);
      @(negedge clk); sample_tick = 1'b1; wr_en = 1'b1; wr_data = 8'h01;
      @(negedge clk); sample_tick = 1'b0; wr_en = 1'b0;
      check(fill_count == 2, "R2 write with pop", fill_count, 2);
      // dark byte played: never lit
      do_clear();
      repeat (3) interval(4, h);
      push(8'h85);
      for (int i = 0; i < 5; i++) begin
         interval(32, h);
         check(h == 0, "R4 dark symbol", h, 0);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule